// File: doc/BRIEF.md
# Sample Sequencer FIFO Controller

This block is the digital back end of a four-sequencer converter. Each sequencer owns a 16-word sample FIFO. The FIFO reports its read pointer, its write pointer and its empty and full flags together in one status word. A single-cycle trigger input starts a scan across the sequencers. A sequencer takes one sample only if it is enabled and its event field selects the timer source. No real converter sits behind the block. Each sample word comes from a pseudo-random noise recurrence.

Software reaches the block through a 32-bit register bus. A read of a sequencer's data register pops one word. Each sequencer drives its own interrupt line, which is its raw flag gated by a mask bit. Writing ones to the status-and-clear register clears raw flags. The block stores the multiplexer, control and housekeeping registers but does not act on them.

The trigger scanner is a two-state machine:
- **SCAN_IDLE** waits for a trigger. The transition *start* (trigger seen) moves to SCAN_RUN with the index set to sequencer 0.
- **SCAN_RUN** visits one sequencer per cycle in ascending order. The transition *step* moves to the next index. The transition *finish* (index 3 handled) returns to SCAN_IDLE.

Top module: `smp_seq_ctrl`

## Requirements
- R1: After reset, every FIFO status word reads 0x100 (empty, both pointers 0). The raw status register (0x04) reads 0 and all interrupt lines are low.
- R2: Sequencer n samples on a trigger only if bit n of the enable register (0x00, bits [3:0]) is set and its event field (bits [4n+3:4n] of register 0x14) equals 5.
- R3: Each sample first advances a 32-bit noise state as noise = noise*314159 + 1, starting from 0 after reset. It then pushes 0x200 + noise[18:16]. Samples are taken in ascending sequencer order.
- R4: Status word layout is: read pointer in [3:0], write pointer in [7:4], empty in bit 8, full in bit 12. A push clears empty and advances the write pointer modulo 16. The status words sit at 0x4C + 0x20*n.
- R5: After 16 unread pushes, full is set and the pointers are equal. A further push is discarded and leaves the status and stored contents unchanged.
- R6: A read of the data register (0x48 + 0x20*n) returns the oldest word and advances the read pointer. Empty is set when the read pointer reaches the write pointer.
- R7: A data read on an empty FIFO returns the most recently removed word and leaves the status word unchanged.
- R8: Every sample sets raw bit n, even when the push is discarded. The line irq[n] equals raw[n] AND mask[n] (mask register 0x08). Register 0x0C reads raw AND mask.
- R9: Writing to 0x0C clears the raw bits written as one and leaves the others unchanged.
- R10: The multiplexer register (0x40 + 0x20*n) stores the written value ANDed with 0x33333333. The control register (0x44 + 0x20*n) stores all 32 bits.
- R11: A scan takes four cycles after the trigger edge. A trigger that arrives while a scan is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Timer trigger strobe, one event per high cycle while idle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; read data is valid the next cycle |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 4 | Per-sequencer interrupt, raw AND mask |

## Verification
The trigger is applied with a mixed configuration: one sequencer is disabled, one has a wrong event field and two qualify. This separates the enable gate from the event-select gate and exposes the order in which noise steps are consumed. A back-to-back trigger pair shows whether a trigger arriving mid-scan is dropped or restarts the scan. A run of seventeen samples into one FIFO, followed by seventeen reads, covers wrap-around of both pointers, the discarded push at full, the return to empty and the stale-word read on an empty FIFO. Mask and clear writes that use differing bit patterns show that the gating and clearing act per bit.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    localparam int SSC_NSEQ   = 4;
    localparam int SSC_DEPTH  = 16;
    localparam int SSC_DW     = 32;
    localparam logic [3:0] SSC_TIMER_SRC = 4'd5;
    localparam logic [31:0] SSC_NOISE_MUL = 32'd314159;
    localparam logic [31:0] SSC_SAMPLE_BASE = 32'h0000_0200;
    localparam logic [31:0] SSC_MUX_KEEP = 32'h3333_3333;

    typedef enum logic [0:0] {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_t;
endpackage

// File: rtl/ssc_fifo.sv
module ssc_fifo
    import ssc_pkg::*;
#(
    parameter int DW    = SSC_DW,
    parameter int DEPTH = SSC_DEPTH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic [31:0]   status
);
    localparam int PW = $clog2(DEPTH);

    logic [DW-1:0] mem_q [DEPTH];
    logic [PW-1:0] rptr_q, wptr_q;
    logic          empty_q, full_q;
    logic          push_ok, pop_ok;
    logic [PW-1:0] rptr_inc, wptr_inc;

    assign push_ok  = push && !full_q;
    assign pop_ok   = pop && !empty_q;
    assign rptr_inc = rptr_q + 1'b1;
    assign wptr_inc = wptr_q + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_q  <= '0;
            wptr_q  <= '0;
            empty_q <= 1'b1;
            full_q  <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (push_ok) begin
                mem_q[wptr_q] <= push_data;
                wptr_q        <= wptr_inc;
            end
            if (pop_ok) rptr_q <= rptr_inc;
            if (push_ok && !pop_ok) begin
                empty_q <= 1'b0;
                full_q  <= (wptr_inc == rptr_q);
            end else if (pop_ok && !push_ok) begin
                full_q  <= 1'b0;
                empty_q <= (rptr_inc == wptr_q);
            end
        end
    end

    always_comb begin
        head_data = empty_q ? mem_q[rptr_q - 1'b1] : mem_q[rptr_q];
        status = '0;
        status[PW-1:0]   = rptr_q;
        status[PW+3:4]   = wptr_q;
        status[8]        = empty_q;
        status[12]       = full_q;
    end

    // R5
    no_full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_q && empty_q));

    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && push && !pop) |=> ($stable(wptr_q) && full_q));

    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_q && pop && !push) |=> ($stable(rptr_q) && empty_q));
endmodule

// File: rtl/ssc_trig_fsm.sv
module ssc_trig_fsm
    import ssc_pkg::*;
#(
    parameter int NSEQ = SSC_NSEQ,
    parameter int DW   = SSC_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [NSEQ-1:0]   active,
    input  logic [4*NSEQ-1:0] esel,
    output logic [NSEQ-1:0]   push_vec,
    output logic [DW-1:0]     push_data
);
    localparam int IW = (NSEQ > 1) ? $clog2(NSEQ) : 1;
    localparam logic [IW-1:0] LAST = IW'(NSEQ - 1);

    scan_state_t   state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;
    logic [31:0]   noise_q, noise_nx;
    logic          hit;

    assign noise_nx = noise_q * SSC_NOISE_MUL + 32'd1;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            SCAN_IDLE: if (trig) begin
                state_d = SCAN_RUN;
                idx_d   = '0;
            end
            SCAN_RUN: begin
                if (idx_q == LAST) state_d = SCAN_IDLE;
                else               idx_d   = idx_q + 1'b1;
            end
            default: state_d = SCAN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCAN_IDLE;
            idx_q   <= '0;
            noise_q <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (hit) noise_q <= noise_nx;
        end
    end

    always_comb begin
        hit       = 1'b0;
        push_vec  = '0;
        push_data = DW'(SSC_SAMPLE_BASE | {29'd0, noise_nx[18:16]});
        unique case (state_q)
            SCAN_IDLE: hit = 1'b0;
            SCAN_RUN:  hit = active[idx_q] && (esel[{idx_q, 2'b00} +: 4] == SSC_TIMER_SRC);
            default:   hit = 1'b0;
        endcase
        for (int n = 0; n < NSEQ; n++)
            if (hit && idx_q == IW'(n)) push_vec[n] = 1'b1;
    end

    // R2
    one_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(push_vec));

    // R11
    scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SCAN_RUN && idx_q != LAST) |=>
        (state_q == SCAN_RUN && idx_q == $past(idx_q) + 1'b1));

    // R11
    scan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SCAN_IDLE && trig) |=> (state_q == SCAN_RUN && idx_q == '0));
endmodule

// File: rtl/smp_seq_ctrl.sv
module smp_seq_ctrl
    import ssc_pkg::*;
#(
    parameter int NSEQ  = SSC_NSEQ,
    parameter int DEPTH = SSC_DEPTH,
    parameter int AW    = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [AW-1:0]   bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic [NSEQ-1:0] irq
);
    localparam int SW = (NSEQ > 1) ? $clog2(NSEQ) : 1;
    localparam logic [AW-1:0] SEQ_BASE = AW'(32'h40);
    localparam logic [AW-1:0] SEQ_END  = AW'(32'h40 + 32'h20 * NSEQ);

    logic [NSEQ-1:0] active_q, raw_q, mask_q;
    logic [31:0]     esel_q, ovf_q, unf_q, pri_q, avg_q;
    logic [31:0]     mux_q [NSEQ];
    logic [31:0]     ctl_q [NSEQ];
    logic [31:0]     status_w [NSEQ];
    logic [31:0]     head_w [NSEQ];
    logic [NSEQ-1:0] push_vec, pop_vec;
    logic [31:0]     push_data;
    logic            seq_hit, isc_wr;
    logic [AW-1:0]   seq_off;
    logic [SW-1:0]   seq_idx;
    logic [31:0]     rd_mux;

    assign seq_hit = (bus_addr >= SEQ_BASE) && (bus_addr < SEQ_END);
    assign seq_off = bus_addr - SEQ_BASE;
    assign seq_idx = seq_off[5 +: SW];
    assign isc_wr  = bus_wr && (bus_addr == AW'(32'h0C));
    assign irq     = raw_q & mask_q;

    ssc_trig_fsm #(.NSEQ(NSEQ), .DW(32)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .active    (active_q),
        .esel      (esel_q[4*NSEQ-1:0]),
        .push_vec  (push_vec),
        .push_data (push_data)
    );

    for (genvar n = 0; n < NSEQ; n++) begin : g_seq
        assign pop_vec[n] = bus_rd && seq_hit && (seq_idx == SW'(n)) && (seq_off[4:0] == 5'h08);

        ssc_fifo #(.DW(32), .DEPTH(DEPTH)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push_vec[n]),
            .push_data (push_data),
            .pop       (pop_vec[n]),
            .head_data (head_w[n]),
            .status    (status_w[n])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mux_q[n] <= '0;
                ctl_q[n] <= '0;
            end else if (bus_wr && seq_hit && seq_idx == SW'(n)) begin
                if (seq_off[4:0] == 5'h00) mux_q[n] <= bus_wdata & SSC_MUX_KEEP;
                if (seq_off[4:0] == 5'h04) ctl_q[n] <= bus_wdata;
            end
        end

        // R9
        raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (isc_wr && bus_wdata[n] && !push_vec[n]) |=> !raw_q[n]);

        // R8
        raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            push_vec[n] |=> raw_q[n]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            raw_q    <= '0;
            mask_q   <= '0;
            esel_q   <= '0;
            ovf_q    <= '0;
            unf_q    <= '0;
            pri_q    <= '0;
            avg_q    <= '0;
        end else begin
            raw_q <= (raw_q & ~(isc_wr ? bus_wdata[NSEQ-1:0] : '0)) | push_vec;
            if (bus_wr) begin
                case (bus_addr)
                    AW'(32'h00): active_q <= bus_wdata[NSEQ-1:0];
                    AW'(32'h08): mask_q   <= bus_wdata[NSEQ-1:0];
                    AW'(32'h10): ovf_q    <= bus_wdata;
                    AW'(32'h14): esel_q   <= bus_wdata;
                    AW'(32'h18): unf_q    <= bus_wdata;
                    AW'(32'h20): pri_q    <= bus_wdata;
                    AW'(32'h30): avg_q    <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (seq_hit) begin
            case (seq_off[4:0])
                5'h00:   rd_mux = mux_q[seq_idx];
                5'h04:   rd_mux = ctl_q[seq_idx];
                5'h08:   rd_mux = head_w[seq_idx];
                5'h0C:   rd_mux = status_w[seq_idx];
                default: rd_mux = '0;
            endcase
        end else begin
            case (bus_addr)
                AW'(32'h00): rd_mux = 32'(active_q);
                AW'(32'h04): rd_mux = 32'(raw_q);
                AW'(32'h08): rd_mux = 32'(mask_q);
                AW'(32'h0C): rd_mux = 32'(raw_q & mask_q);
                AW'(32'h10): rd_mux = ovf_q;
                AW'(32'h14): rd_mux = esel_q;
                AW'(32'h18): rd_mux = unf_q;
                AW'(32'h20): rd_mux = pri_q;
                AW'(32'h30): rd_mux = avg_q;
                default:     rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: tb/smp_seq_ctrl_bench.sv
module smp_seq_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int checks = 0;
    int fails = 0;
    logic [31:0] noise_m = '0;
    logic [31:0] q0 [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    smp_seq_ctrl u_smp_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .trig(trig), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] next_sample();
        noise_m = noise_m * 32'd314159 + 32'd1;
        return 32'h200 + {29'd0, noise_m[18:16]};
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic pulse_trig(input int width);
        @(negedge clk); trig = 1'b1;
        repeat (width) @(negedge clk);
        trig = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int n = 0; n < 4; n++) begin
            rd(12'h04C + 12'(32 * n), d);
            chk("R1 status after reset", d, 32'h100);
        end
        rd(12'h004, d);
        chk("R1 raw after reset", d, 0);
        chk("R1 irq after reset", 32'(irq), 0);
    endtask

    task automatic t_select();
        logic [31:0] d, e0, e1;
        wr(12'h014, 32'h0000_5355);
        wr(12'h000, 32'h7);
        pulse_trig(1);
        e0 = next_sample();
        e1 = next_sample();
        rd(12'h04C, d); chk("R2 R4 seq0 sampled", d, 32'h010);
        rd(12'h06C, d); chk("R2 R4 seq1 sampled", d, 32'h010);
        rd(12'h08C, d); chk("R2 seq2 wrong event", d, 32'h100);
        rd(12'h0AC, d); chk("R2 seq3 disabled", d, 32'h100);
        rd(12'h048, d); chk("R3 seq0 value", d, e0);
        rd(12'h068, d); chk("R3 seq1 value", d, e1);
        rd(12'h04C, d); chk("R6 seq0 empty after pop", d, 32'h111);
        rd(12'h004, d); chk("R8 raw bits", d, 32'h3);
        chk("R8 irq masked off", 32'(irq), 0);
        wr(12'h008, 32'h2);
        @(negedge clk);
        chk("R8 irq gated by mask", 32'(irq), 32'h2);
        rd(12'h00C, d); chk("R8 masked status", d, 32'h2);
        wr(12'h00C, 32'h1);
        rd(12'h004, d); chk("R9 clear bit0 only", d, 32'h2);
        wr(12'h00C, 32'h2);
        rd(12'h004, d); chk("R9 clear bit1", d, 0);
        chk("R9 irq low after clear", 32'(irq), 0);
    endtask

    task automatic t_double_trig();
        logic [31:0] d;
        wr(12'h000, 32'h1);
        pulse_trig(2);
        q0.push_back(next_sample());
        rd(12'h04C, d); chk("R11 second trigger ignored", d, 32'h021);
    endtask

    task automatic t_full();
        logic [31:0] d, s;
        for (int k = 0; k < 15; k++) begin
            pulse_trig(1);
            q0.push_back(next_sample());
        end
        rd(12'h04C, d); chk("R5 full status", d, 32'h1011);
        pulse_trig(1);
        s = next_sample();
        rd(12'h04C, d); chk("R5 push at full discarded", d, 32'h1011);
        rd(12'h004, d); chk("R8 raw set on discarded push", d, 32'h1);
        for (int k = 0; k < 16; k++) begin
            rd(12'h048, d);
            s = q0.pop_front();
            chk("R6 R5 fifo order", d, s);
        end
        rd(12'h04C, d); chk("R6 empty after drain", d, 32'h111);
        rd(12'h048, d); chk("R7 empty read value", d, s);
        rd(12'h04C, d); chk("R7 empty read keeps status", d, 32'h111);
    endtask

    task automatic t_stored();
        logic [31:0] d;
        wr(12'h060, 32'hFFFF_FFFF);
        rd(12'h060, d); chk("R10 mux masked", d, 32'h3333_3333);
        wr(12'h0A4, 32'hDEAD_BEEF);
        rd(12'h0A4, d); chk("R10 control stored", d, 32'hDEAD_BEEF);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        checks++;
        $display("FAIL R11 watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select();
        t_double_trig();
        t_full();
        t_stored();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule